// File: doc/BRIEF.md
# Charger fault event reporter

This block sits beside the control logic of a single-cell battery charger and turns fault events into something a host can read and act on. Each fault source raises a one-cycle strobe. The block gives the fault its 4-bit code and places it in an ordered pending list. The host reads one status byte. Each read strobe consumes the fault currently shown, so repeated reads of the same byte walk through every fault that occurred. Every fault that enters the list also starts a fixed-length pulse on the interrupt output and on the status output. The pulse length is counted in microsecond ticks supplied from outside.

The status byte also carries a 2-bit charge state and two watchdog bits that pass straight through. A separate 2-bit field records which regulation loop became active first, and it keeps that value until the host reads it. Detecting the faults in the analog domain and the serial bus that carries the reads both sit outside this block.

Top module: `chg_fault_reporter`

## Requirements
- R1: Strobe bit i of `fault_evt` stands for fault code i+1. With the default ten sources the codes are: 1 input overvoltage, 2 input undervoltage lockout, 3 sleep, 4 battery temperature, 5 battery overvoltage, 6 die thermal shutdown, 7 safety timer expiry, 8 battery missing, 9 charge-current resistor shorted, 10 input fault with regulator low. Code 0 means no fault.
- R2: `stat_byte[3:0]` shows the oldest pending code. A cycle with `rd_stb` high removes that code, and the next code then appears. When several strobes arrive in the same cycle, they are queued in ascending code order.
- R3: If a strobe's code is already pending, the strobe is not queued again, and it does not start a pulse.
- R4: At most `QUEUE_DEPTH` codes can be pending at once. Strobes that arrive while the list is full are discarded. When the list has room for only some of the strobes in a cycle, the lower codes are kept.
- R5: When the list is empty, `stat_byte[3:0]` shows the lowest code whose `fault_act` level is high. It shows 0000 only when the list is empty and no fault level is active.
- R6: `stat_byte[5:4]` encodes the charge state. It reads 11 (fault) whenever the fault field is nonzero. Otherwise it reads 10 (done) if `chg_done` is high, then 01 (charging) if `chg_run` is high, and 00 (ready) if neither is high.
- R7: `stat_byte[7]` equals `wd_fault` and `stat_byte[6]` equals `wd_en`.
- R8: A strobe that is accepted into the list drives `int_pulse` and `stat_pulse` high from the next cycle. The pulses stay high until `PULSE_US` cycles carrying `us_tick` have passed.
- R9: A fault accepted while a pulse is still running restarts the full `PULSE_US` count.
- R10: `loop_stat` encodes the regulation loops as 00 none, 01 input-voltage limit, 10 input-current limit, 11 die thermal. Request bits 0, 1 and 2 map to codes 01, 10 and 11. While the field is 00, the lowest active request is captured. The field then holds that value until a `loop_rd` cycle clears it to 00.
- R11: After reset the list is empty, both pulses are low and `loop_stat` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | NUM_FAULTS | One-cycle fault strobes; bit i gives code i+1 |
| fault_act | input | NUM_FAULTS | Level of each fault that is still present |
| chg_run | input | 1 | Charging in progress |
| chg_done | input | 1 | Charging finished |
| wd_fault | input | 1 | Watchdog fault flag, shown in bit 7 |
| wd_en | input | 1 | Watchdog enable, shown in bit 6 |
| rd_stb | input | 1 | Host read of the status byte; consumes the shown code |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| loop_req | input | 3 | Active regulation loops: input voltage, input current, thermal |
| loop_rd | input | 1 | Host read of the loop field; clears it |
| stat_byte | output | 8 | Watchdog bits, charge state and fault code |
| loop_stat | output | 2 | Latched first regulation loop |
| int_pulse | output | 1 | Interrupt pulse |
| stat_pulse | output | 1 | Status pin pulse |

## Verification
The bench builds the block with `QUEUE_DEPTH` = 4 and `PULSE_US` = 5, and it drives a tick every third cycle. With the small depth, a single cycle with five strobes overflows the list and shows which code gets dropped. With the short pulse, a pulse ends and a pulse restarts within a few tens of cycles. The default ten fault sources are kept, so every code from 1 to 10 can be reached, including ties between simultaneous strobes and the fallback to live fault levels.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] fcode_t;

  typedef enum logic [1:0] {
    ST_READY    = 2'b00,
    ST_CHARGING = 2'b01,
    ST_DONE     = 2'b10,
    ST_FAULT    = 2'b11
  } chg_state_e;

  typedef enum logic [1:0] {
    LP_NONE  = 2'b00,
    LP_VDPM  = 2'b01,
    LP_ILIM  = 2'b10,
    LP_THERM = 2'b11
  } loop_e;

  // source index -> reported code (index 0 is code 1)
  function automatic fcode_t idx_to_code(int idx);
    return fcode_t'(idx + 1);
  endfunction

  // charge state shown to the host: fault wins, then done, then charging
  function automatic chg_state_e fold_state(logic fault, logic done, logic run);
    if (fault)     return ST_FAULT;
    else if (done) return ST_DONE;
    else if (run)  return ST_CHARGING;
    else           return ST_READY;
  endfunction
endpackage

// File: rtl/cfr_fault_queue.sv
module cfr_fault_queue
  import cfr_pkg::*;
#(
  parameter int NF    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] evt,
  input  logic          pop,
  output fcode_t        head,
  output logic          empty,
  output logic [NF-1:0] taken
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  fcode_t          slots [DEPTH];
  logic [PW-1:0]   rd_ptr;
  logic [CNTW-1:0] cnt;
  logic [NF-1:0]   pend;
  logic [NF-1:0]   pend_left;
  logic            do_pop;
  logic [PW-1:0]   wr_at [NF];
  logic [CNTW-1:0] cnt_next;

  function automatic logic [PW-1:0] ring_at(logic [PW-1:0] base, int off);
    return PW'((int'(base) + off) % DEPTH);
  endfunction

  function automatic logic [NF-1:0] code_mask(fcode_t c);
    logic [NF-1:0] m;
    for (int i = 0; i < NF; i++) m[i] = (c == idx_to_code(i));
    return m;
  endfunction

  // pop first, then admit new codes in ascending order while room remains
  always_comb begin
    int room;
    int rank;
    do_pop    = pop && (cnt != '0);
    pend_left = do_pop ? (pend & ~code_mask(slots[rd_ptr])) : pend;
    room      = DEPTH - int'(cnt) + (do_pop ? 1 : 0);
    rank      = 0;
    taken     = '0;
    for (int i = 0; i < NF; i++) begin
      wr_at[i] = ring_at(rd_ptr, int'(cnt) + rank);
      if (evt[i] && !pend_left[i] && (rank < room)) begin
        taken[i] = 1'b1;
        rank     = rank + 1;
      end
    end
    cnt_next = CNTW'(int'(cnt) - (do_pop ? 1 : 0) + rank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      pend   <= '0;
    end else begin
      if (do_pop) rd_ptr <= ring_at(rd_ptr, 1);
      cnt  <= cnt_next;
      pend <= pend_left | taken;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NF; i++) begin
      if (taken[i]) slots[wr_at[i]] <= idx_to_code(i);
    end
  end

  assign empty = (cnt == '0);
  assign head  = empty ? '0 : slots[rd_ptr];
endmodule

// File: rtl/cfr_pulse_timer.sv
module cfr_pulse_timer #(
  parameter int WIDTH_US = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic us_tick,
  output logic pulse
);
  localparam int TW = $clog2(WIDTH_US + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left <= '0;
    else if (fire)                   left <= TW'(WIDTH_US);
    else if (us_tick && left != '0)  left <= left - TW'(1);
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/cfr_loop_latch.sv
module cfr_loop_latch
  import cfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] loop_req,
  input  logic       clr,
  output loop_e      held
);
  function automatic loop_e first_loop(logic [2:0] r);
    if (r[0])      return LP_VDPM;
    else if (r[1]) return LP_ILIM;
    else if (r[2]) return LP_THERM;
    else           return LP_NONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                held <= LP_NONE;
    else if (clr)              held <= LP_NONE;
    else if (held == LP_NONE)  held <= first_loop(loop_req);
  end
endmodule

// File: rtl/chg_fault_reporter.sv
module chg_fault_reporter
  import cfr_pkg::*;
#(
  parameter int NUM_FAULTS  = 10,
  parameter int QUEUE_DEPTH = 8,
  parameter int PULSE_US    = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_evt,
  input  logic [NUM_FAULTS-1:0] fault_act,
  input  logic                  chg_run,
  input  logic                  chg_done,
  input  logic                  wd_fault,
  input  logic                  wd_en,
  input  logic                  rd_stb,
  input  logic                  us_tick,
  input  logic [2:0]            loop_req,
  input  logic                  loop_rd,
  output logic [7:0]            stat_byte,
  output logic [1:0]            loop_stat,
  output logic                  int_pulse,
  output logic                  stat_pulse
);
  localparam int NPULSE = 2;

  fcode_t                q_head;
  logic                  q_empty;
  logic [NUM_FAULTS-1:0] q_taken;
  logic                  fault_fire;
  fcode_t                act_code;
  fcode_t                shown_code;
  chg_state_e            shown_state;
  loop_e                 loop_q;
  logic [NPULSE-1:0]     pulses;

  function automatic fcode_t lowest_active(logic [NUM_FAULTS-1:0] a);
    fcode_t c = '0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (a[i]) c = idx_to_code(i);
    end
    return c;
  endfunction

  cfr_fault_queue #(
    .NF    (NUM_FAULTS),
    .DEPTH (QUEUE_DEPTH)
  ) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (fault_evt),
    .pop   (rd_stb),
    .head  (q_head),
    .empty (q_empty),
    .taken (q_taken)
  );

  assign fault_fire = |q_taken;

  // one timer per pulsed output (interrupt, status pin)
  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    cfr_pulse_timer #(
      .WIDTH_US (PULSE_US)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fault_fire),
      .us_tick (us_tick),
      .pulse   (pulses[g])
    );
  end

  cfr_loop_latch u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_req (loop_req),
    .clr      (loop_rd),
    .held     (loop_q)
  );

  assign act_code    = lowest_active(fault_act);
  assign shown_code  = q_empty ? act_code : q_head;
  assign shown_state = fold_state(shown_code != '0, chg_done, chg_run);

  assign stat_byte  = {wd_fault, wd_en, shown_state, shown_code};
  assign loop_stat  = loop_q;
  assign int_pulse  = pulses[0];
  assign stat_pulse = pulses[1];
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int NF = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_fire,
  input logic          q_empty,
  input logic [NF-1:0] fault_act,
  input logic          us_tick,
  input logic          int_pulse,
  input logic          stat_pulse,
  input logic [7:0]    stat_byte,
  input logic [1:0]    loop_stat,
  input logic          loop_rd
);
  // R8
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> (int_pulse && stat_pulse));

  // R8
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_fire && !us_tick) |=> ($stable(int_pulse) && $stable(stat_pulse)));

  // R2
  empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !fault_fire) |=> q_empty);

  // R5
  normal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && fault_act == '0) |-> (stat_byte[3:0] == 4'd0));

  // R6
  fault_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[3:0] != 4'd0) |-> (stat_byte[5:4] == 2'b11));

  // R10
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_stat != 2'b00 && !loop_rd) |=> $stable(loop_stat));

  // R10
  loop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rd |=> (loop_stat == 2'b00));
endmodule

bind chg_fault_reporter cfr_checker #(.NF(NUM_FAULTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_fire (fault_fire),
  .q_empty    (q_empty),
  .fault_act  (fault_act),
  .us_tick    (us_tick),
  .int_pulse  (int_pulse),
  .stat_pulse (stat_pulse),
  .stat_byte  (stat_byte),
  .loop_stat  (loop_stat),
  .loop_rd    (loop_rd)
);

// File: tb/sim_chg_fault_reporter.sv
`timescale 1ns/1ps
module sim_chg_fault_reporter;
  localparam int NF    = 10;
  localparam int DEPTH = 4;
  localparam int PULSE = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] fault_evt = '0;
  logic [NF-1:0] fault_act = '0;
  logic          chg_run = 1'b0;
  logic          chg_done = 1'b0;
  logic          wd_fault = 1'b1;
  logic          wd_en = 1'b0;
  logic          rd_stb = 1'b0;
  logic          us_tick = 1'b0;
  logic [2:0]    loop_req = '0;
  logic          loop_rd = 1'b0;
  logic [7:0]    stat_byte;
  logic [1:0]    loop_stat;
  logic          int_pulse;
  logic          stat_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int mq[$];
  int mp = 0;
  int ml = 0;

  always #2 clk = ~clk;

  chg_fault_reporter #(
    .NUM_FAULTS  (NF),
    .QUEUE_DEPTH (DEPTH),
    .PULSE_US    (PULSE)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_evt  (fault_evt),
    .fault_act  (fault_act),
    .chg_run    (chg_run),
    .chg_done   (chg_done),
    .wd_fault   (wd_fault),
    .wd_en      (wd_en),
    .rd_stb     (rd_stb),
    .us_tick    (us_tick),
    .loop_req   (loop_req),
    .loop_rd    (loop_rd),
    .stat_byte  (stat_byte),
    .loop_stat  (loop_stat),
    .int_pulse  (int_pulse),
    .stat_pulse (stat_pulse)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit in_q(int code);
    foreach (mq[k]) if (mq[k] == code) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_field();
    if (mq.size() > 0) return mq[0];
    for (int i = 0; i < NF; i++) if (fault_act[i]) return i + 1;
    return 0;
  endfunction

  function automatic int exp_state();
    if (exp_field() != 0) return 3;
    if (chg_done)         return 2;
    if (chg_run)          return 1;
    return 0;
  endfunction

  task automatic compare();
    check("R2/R5 fault field", int'(stat_byte[3:0]), exp_field());
    check("R6 charge state", int'(stat_byte[5:4]), exp_state());
    check("R7 watchdog bits", int'(stat_byte[7:6]), int'({wd_fault, wd_en}));
    check("R8 int pulse", int'(int_pulse), (mp > 0) ? 1 : 0);
    check("R8 stat pulse", int'(stat_pulse), (mp > 0) ? 1 : 0);
    check("R10 loop field", int'(loop_stat), ml);
  endtask

  task automatic model_update();
    bit acc = 1'b0;
    if (rd_stb && mq.size() > 0) void'(mq.pop_front());
    for (int i = 0; i < NF; i++) begin
      if (fault_evt[i] && !in_q(i + 1) && mq.size() < DEPTH) begin
        mq.push_back(i + 1);
        acc = 1'b1;
      end
    end
    if (acc) mp = PULSE;
    else if (us_tick && mp > 0) mp--;
    if (loop_rd) ml = 0;
    else if (ml == 0) begin
      if (loop_req[0])      ml = 1;
      else if (loop_req[1]) ml = 2;
      else if (loop_req[2]) ml = 3;
    end
  endtask

  task automatic step();
    us_tick = (cyc % 3 == 0);
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    cyc++;
    fault_evt = '0;
    rd_stb    = 1'b0;
    loop_rd   = 1'b0;
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all) actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 and R7: reset state with watchdog bits passed through
    check("R11 reset byte", int'(stat_byte), 8'h80);
    check("R11 reset int", int'(int_pulse), 0);
    check("R11 reset loop", int'(loop_stat), 0);

    // R6 state encoding without faults
    chg_run = 1'b1;
    steps(1);
    check("R6 charging", int'(stat_byte[5:4]), 1);
    chg_done = 1'b1;
    steps(1);
    check("R6 done over charging", int'(stat_byte[5:4]), 2);

    // R1 single event, code mapping
    fault_evt[4] = 1'b1;
    steps(1);
    check("R1 battery overvoltage code", int'(stat_byte[3:0]), 5);
    check("R8 pulse starts", int'(int_pulse), 1);
    check("R6 fault state", int'(stat_byte[5:4]), 3);
    steps(20);
    check("R8 pulse ended", int'(int_pulse), 0);
    rd_stb = 1'b1;
    steps(1);
    check("R2 drained", int'(stat_byte[3:0]), 0);

    // R2 simultaneous events, ascending order
    fault_evt[6] = 1'b1;
    fault_evt[1] = 1'b1;
    steps(1);
    check("R2 lower code first", int'(stat_byte[3:0]), 2);
    rd_stb = 1'b1;
    steps(1);
    check("R2 next code", int'(stat_byte[3:0]), 7);
    rd_stb = 1'b1;
    steps(1);
    check("R2 empty after reads", int'(stat_byte[3:0]), 0);

    // R3 duplicate not queued twice
    fault_evt[0] = 1'b1;
    steps(1);
    fault_evt[0] = 1'b1;
    steps(1);
    rd_stb = 1'b1;
    steps(1);
    check("R3 duplicate dropped", int'(stat_byte[3:0]), 0);
    steps(20);

    // R4 overflow: five strobes, depth four
    fault_evt = 10'b00000_11111;
    steps(1);
    for (int c = 1; c <= 4; c++) begin
      check("R4 kept code", int'(stat_byte[3:0]), c);
      rd_stb = 1'b1;
      steps(1);
    end
    check("R4 fifth code dropped", int'(stat_byte[3:0]), 0);

    // R5 live fault level with empty list
    fault_act[8] = 1'b1;
    fault_act[9] = 1'b1;
    steps(1);
    check("R5 lowest active code", int'(stat_byte[3:0]), 9);
    fault_act = '0;
    steps(1);
    check("R5 back to normal", int'(stat_byte[3:0]), 0);
    steps(20);

    // R9 restart of a running pulse
    fault_evt[2] = 1'b1;
    steps(1);
    steps(8);
    fault_evt[3] = 1'b1;
    steps(1);
    steps(10);
    check("R9 pulse restarted", int'(int_pulse), 1);
    rd_stb = 1'b1;
    steps(1);
    rd_stb = 1'b1;
    steps(1);

    // R10 loop capture, hold and clear
    loop_req = 3'b110;
    steps(1);
    check("R10 first loop captured", int'(loop_stat), 2);
    loop_req = 3'b001;
    steps(2);
    check("R10 loop held", int'(loop_stat), 2);
    loop_rd = 1'b1;
    steps(1);
    check("R10 loop cleared", int'(loop_stat), 0);
    steps(1);
    check("R10 new loop captured", int'(loop_stat), 1);
    loop_req = '0;

    // R7 watchdog bits follow inputs
    wd_en = 1'b1;
    wd_fault = 1'b0;
    steps(2);
    check("R7 watchdog bits", int'(stat_byte[7:6]), 1);
    chg_done = 1'b0;
    chg_run = 1'b0;
    steps(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule